// File: doc/BRIEF.md
# Serial Shift Register with Output Latch

This block is a left-shifting data register for a general serial port. A processor-side port can load the register in parallel and read it back at any time. Each shift moves every bit one place toward the most significant bit and takes a new bit into bit 0 from the serial data input. Three clock sources can drive the shift: an edge of an external serial clock, a compare-match pulse from a timer, or a software strobe. The register can also be left idle.

The most significant bit reaches the serial data output through a latch. With the external clock selected, the latch passes data only during the half of the serial clock period that follows the active shift edge. It holds during the other half, so the far end samples and this end drives on opposite edges. With an internal source selected, or with the block idle, the latch is always open, and a new MSB shows at the pin as soon as it lands in the register. The external clock and the data input are synchronized to the system clock before use. A parameter selects the polarity of the active edge.

Top module: `serial_shift_reg`

## Requirements
- R1: After reset the register reads 0x00 and the serial output is 0.
- R2: When `wr_en` is high at a clock edge, the register takes `wr_data`. `rd_data` always returns the current register contents.
- R3: With `clk_sel` = 2'b11 (software), a high `soft_strobe` at a clock edge shifts the register left by one and loads `ser_data_in` into bit 0.
- R4: With `clk_sel` = 2'b10 (timer), a high `timer_match` at a clock edge shifts the register left by one and loads `ser_data_in` into bit 0.
- R5: With `clk_sel` = 2'b01 (external), each active edge of `ser_clk_in` causes exactly one left shift after synchronization. The active edge is rising when SHIFT_ON_RISE = 1. The bit loaded is `ser_data_in` as it stood at that edge. The opposite edge causes no shift.
- R6: If a write and a shift fall in the same cycle, the register takes the written value and does not shift.
- R7: A pulse from a source that `clk_sel` does not select has no effect on the register. With `clk_sel` = 2'b00, only writes change it.
- R8: With `clk_sel` set to 2'b00, 2'b10 or 2'b11, `ser_data_out` equals bit 7 of the register in every cycle.
- R9: With `clk_sel` = 2'b01, `ser_data_out` follows bit 7 while the synchronized serial clock is at its active level. While the clock is at its inactive level, the output holds the value it had when the clock left the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Shift source: 00 idle, 01 external, 10 timer, 11 software |
| wr_en | input | 1 | Parallel write enable |
| wr_data | input | WIDTH | Parallel write data |
| rd_data | output | WIDTH | Current register contents |
| soft_strobe | input | 1 | Software shift strobe |
| timer_match | input | 1 | Timer compare-match pulse |
| ser_clk_in | input | 1 | External serial clock |
| ser_data_in | input | 1 | Serial data input |
| ser_data_out | output | 1 | Latched serial data output |

## Verification
The bench builds the block with WIDTH = 8, SHIFT_ON_RISE = 1 and SYNC_STAGES = 3. The deeper synchronizer makes the external path four register stages long, so the bench waits well past it before each check. A miscounted delay in the edge detector then appears as a wrong shift count or a wrong latched bit. The random phase runs only the internal and idle modes, where the outcome of each cycle can be predicted exactly. It mixes writes, strobes, timer pulses and collisions. Directed sequences cover the external-clock edges and the latch hold interval.

// File: rtl/serial_shift_reg.sv
module serial_shift_reg #(
  parameter int WIDTH         = 8,
  parameter int SYNC_STAGES   = 2,
  parameter bit SHIFT_ON_RISE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             soft_strobe,
  input  logic             timer_match,
  input  logic             ser_clk_in,
  input  logic             ser_data_in,
  output logic             ser_data_out
);
  localparam int MSB = WIDTH - 1;
  localparam int LST = SYNC_STAGES - 1;

  logic [LST:0]   clk_sync, dat_sync;
  logic           clk_prev, held_q;
  logic [MSB:0]   shreg_q;
  logic           ext_sel, ext_level, ext_edge, shift_now, shift_bit, latch_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[LST-1:0], ser_clk_in};
      dat_sync <= {dat_sync[LST-1:0], ser_data_in};
      clk_prev <= clk_sync[LST];
    end
  end

  assign ext_sel   = (clk_sel == 2'b01);
  assign ext_level = SHIFT_ON_RISE ? clk_sync[LST] : ~clk_sync[LST];
  assign ext_edge  = SHIFT_ON_RISE ? (clk_sync[LST] & ~clk_prev)
                                   : (~clk_sync[LST] & clk_prev);

  always_comb begin
    case (clk_sel)
      2'b01:   shift_now = ext_edge;
      2'b10:   shift_now = timer_match;
      2'b11:   shift_now = soft_strobe;
      default: shift_now = 1'b0;
    endcase
  end

  assign shift_bit = ext_sel ? dat_sync[LST] : ser_data_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg_q <= '0;
    else if (wr_en)     shreg_q <= wr_data;
    else if (shift_now) shreg_q <= {shreg_q[MSB-1:0], shift_bit};
  end

  assign latch_open   = ~ext_sel | ext_level;
  assign ser_data_out = latch_open ? shreg_q[MSB] : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= ser_data_out;
  end

  assign rd_data = shreg_q;
endmodule

// File: rtl/serial_shift_reg_chk.sv
module serial_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       clk_sel,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             soft_strobe,
  input logic             timer_match,
  input logic             ser_data_in,
  input logic [WIDTH-1:0] rd_data,
  input logic             ser_data_out
);
  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (soft_strobe || timer_match)) |=> rd_data == $past(wr_data));

  p_soft_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && clk_sel == 2'b11 && soft_strobe) |=>
      rd_data == {$past(rd_data[WIDTH-2:0]), $past(ser_data_in)});

  p_timer_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && clk_sel == 2'b10 && timer_match) |=>
      rd_data == {$past(rd_data[WIDTH-2:0]), $past(ser_data_in)});

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && clk_sel == 2'b00) |=> $stable(rd_data));

  p_open_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != 2'b01) |-> ser_data_out == rd_data[WIDTH-1]);
endmodule

bind serial_shift_reg serial_shift_reg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en),
  .wr_data(wr_data), .soft_strobe(soft_strobe), .timer_match(timer_match),
  .ser_data_in(ser_data_in), .rd_data(rd_data), .ser_data_out(ser_data_out));

// File: tb/serial_shift_reg_tb_top.sv
module serial_shift_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       soft_strobe = 1'b0;
  logic       timer_match = 1'b0;
  logic       ser_clk_in = 1'b0;
  logic       ser_data_in = 1'b0;
  logic       ser_data_out;
  int         checks = 0;
  int         failures = 0;
  logic [7:0] model = 8'h00;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  serial_shift_reg #(.WIDTH(8), .SYNC_STAGES(3), .SHIFT_ON_RISE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .soft_strobe(soft_strobe),
    .timer_match(timer_match), .ser_clk_in(ser_clk_in),
    .ser_data_in(ser_data_in), .ser_data_out(ser_data_out));

  function automatic logic [7:0] next_val(logic [7:0] cur, logic [1:0] sel,
      logic we, logic [7:0] wd, logic st, logic tm, logic din);
    if (we) return wd;
    if ((sel == 2'b11 && st) || (sel == 2'b10 && tm)) return {cur[6:0], din};
    return cur;
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic step(logic [1:0] sel, logic we, logic [7:0] wd,
                      logic st, logic tm, logic din);
    clk_sel = sel; wr_en = we; wr_data = wd;
    soft_strobe = st; timer_match = tm; ser_data_in = din;
    model = next_val(model, sel, we, wd, st, tm, din);
    cyc(1);
    wr_en = 1'b0; soft_strobe = 1'b0; timer_match = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(2);
    check8("R1 reset value", rd_data, 8'h00);
    check1("R1 reset output", ser_data_out, 1'b0);
    rst_n = 1'b1;
    cyc(1);

    step(2'b00, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
    check8("R2 write", rd_data, 8'hA5);
    check1("R8 out after write", ser_data_out, 1'b1);

    step(2'b11, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check8("R3 soft shift", rd_data, 8'h4B);
    check1("R8 out after soft shift", ser_data_out, 1'b0);

    step(2'b10, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check8("R4 timer shift", rd_data, 8'h96);

    step(2'b10, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check8("R7 soft ignored in timer mode", rd_data, 8'h96);
    step(2'b11, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    check8("R7 timer ignored in soft mode", rd_data, 8'h96);
    step(2'b00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    check8("R7 idle mode holds", rd_data, 8'h96);

    step(2'b11, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1);
    check8("R6 write wins over soft", rd_data, 8'h3C);
    step(2'b10, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0);
    check8("R6 write wins over timer", rd_data, 8'hC3);

    for (int k = 0; k < 400; k++) begin
      logic [1:0] sel;
      case ($urandom % 3)
        0: sel = 2'b00;
        1: sel = 2'b10;
        default: sel = 2'b11;
      endcase
      step(sel, ($urandom % 4) == 0, 8'($urandom), $urandom % 2,
           $urandom % 2, $urandom % 2);
      check8("R2 R3 R4 R6 R7 random", rd_data, model);
      check1("R8 random out", ser_data_out, model[7]);
    end

    step(2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    clk_sel = 2'b01; ser_clk_in = 1'b0;
    cyc(6);
    step(2'b01, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0);
    check8("R2 write in external mode", rd_data, 8'h40);
    ser_data_in = 1'b1; ser_clk_in = 1'b1;
    cyc(7);
    check8("R5 rising edge shifts once", rd_data, 8'h81);
    check1("R9 latch open in active half", ser_data_out, 1'b1);
    ser_data_in = 1'b0; ser_clk_in = 1'b0;
    cyc(7);
    check8("R5 falling edge no shift", rd_data, 8'h81);
    check1("R9 held after close", ser_data_out, 1'b1);
    step(2'b01, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    check8("R2 write during hold", rd_data, 8'h00);
    check1("R9 output holds during inactive half", ser_data_out, 1'b1);
    ser_clk_in = 1'b1;
    cyc(7);
    check8("R5 second edge shifts in 0", rd_data, 8'h00);
    check1("R9 latch reopens", ser_data_out, 1'b0);
    step(2'b01, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0);
    check1("R9 transparent write shows at once", ser_data_out, 1'b1);
    ser_clk_in = 1'b0;
    cyc(7);
    step(2'b01, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    check8("R7 internal pulses ignored in external mode", rd_data, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule